// File: doc/BRIEF.md
# Inverted Page Table Hash Lookup

This block finds which physical frame holds a given (process id, virtual page number) pair. It keeps a small table with exactly one entry per physical frame, so its size depends only on the number of frames and not on the size of the virtual address space. Each entry records a page number, an owning process id, an occupied flag, a modify flag and a link to the next entry in its collision chain. The slot index of an entry is the frame number it describes.

A request hashes its page number to a home slot. The walker then reads one entry per clock and follows links until it finds an entry whose page number and process id both equal the request, or until it reaches the end of the chain. Chains may merge: an entry placed in a slot that is some other page's home joins the chain that already passes through that slot. Lookups never hit a wrong entry, because a match needs both the page number and the process id to be equal.

Lookups use a request channel and a response channel, both with valid/ready. A request is taken on a clock edge where `lk_valid` and `lk_ready` are both high. A response stays on `rsp_*` and does not change until the edge where `rsp_ready` is high. While a response waits, no new request is taken. A separate insert channel fills the table. It also uses valid/ready, and each insert reports its result on plain status pins for one cycle.

Top module: `invpt_lookup`

## Requirements
- R1: After reset `rsp_valid` and `ins_done` are low, `ins_ready` is high, `lk_ready` is high while `ins_valid` is low, and every lookup misses because the table is empty.
- R2: A walk begins at the home slot, which is the page number modulo the frame count. With the default 8 frames this is the page number's three low bits.
- R3: `rsp_hit` is 1 only for an occupied entry whose page number and process id both equal the request. `rsp_frame` is then that entry's slot index. The same page number under a different process id misses.
- R4: A link whose most significant bit is set (value 8 in the default 4-bit link) is the null end marker. An unoccupied home slot also ends the walk. A walk that ends with no match gives `rsp_hit`=0, `rsp_frame`=0 and `rsp_dirty`=0.
- R5: The walker reads one entry per cycle and reads at most one entry per frame in the table. If the deciding entry is at position p (counting from 0) in the walk, `rsp_valid` rises on the (p+1)-th rising edge after the edge that took the request.
- R6: An insert whose home slot is unoccupied writes the entry there and gives `ins_ok`=1 and `ins_frame` equal to the home slot.
- R7: An insert whose home slot is occupied walks to the tail of the chain through that slot. It writes the entry into the lowest-numbered unoccupied slot, links the old tail to it, and reports that slot in `ins_frame`.
- R8: An insert into a full table gives `ins_ok`=0 and leaves every entry and link unchanged.
- R9: A hit returns the modify flag that was stored with the entry on `rsp_dirty`.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and `lk_ready` is low. The response drops one edge after `rsp_ready` is seen high.
- R11: When the walker is idle and both channels are valid, the insert is taken first, and `lk_ready` stays low while `ins_valid` is high. `ins_done` is a single-cycle pulse for each insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_pid | input | PID_W | Lookup process id |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Matching entry found |
| rsp_frame | output | IDX_W | Frame (slot) number of the hit |
| rsp_dirty | output | 1 | Stored modify flag of the hit |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Insert request can be taken |
| ins_pid | input | PID_W | Insert process id |
| ins_vpn | input | VPN_W | Insert virtual page number |
| ins_dirty | input | 1 | Insert modify flag |
| ins_done | output | 1 | One-cycle pulse when an insert completes |
| ins_ok | output | 1 | Insert placed (valid while `ins_done` is high) |
| ins_frame | output | IDX_W | Slot written by the insert |

## Verification
The hardest case to reach is a long merged chain: a walk that passes through entries whose home slot is a different one before it reaches its target. This case also gives the largest response latency. The stimulus gets there by inserting several pages that share one home slot, so they spill into low free slots. It then inserts a page whose home is one of those spill slots, so its chain joins the longer one. It fills the table to capacity and then sweeps every process id and page number pair. A plain arithmetic model predicts the hit, frame, modify flag and exact latency for each pair.

// File: rtl/invpt_pkg.sv
package invpt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_RESP = 2'd2
  } walk_state_e;

  typedef enum logic {
    OP_LOOKUP = 1'b0,
    OP_INSERT = 1'b1
  } walk_op_e;

endpackage

// File: rtl/invpt_entry_store.sv
module invpt_entry_store #(
  parameter int N     = 8,
  parameter int VPN_W = 6,
  parameter int PID_W = 2,
  parameter int IDX_W = $clog2(N),
  parameter int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [VPN_W-1:0] rd_vpn,
  output logic [PID_W-1:0] rd_pid,
  output logic             rd_dirty,
  output logic [PTR_W-1:0] rd_next,
  input  logic             new_en,
  input  logic [IDX_W-1:0] new_idx,
  input  logic [VPN_W-1:0] new_vpn,
  input  logic [PID_W-1:0] new_pid,
  input  logic             new_dirty,
  input  logic             link_en,
  input  logic [IDX_W-1:0] link_idx,
  input  logic [PTR_W-1:0] link_ptr,
  output logic [N-1:0]     free_mask
);

  localparam logic [PTR_W-1:0] NULL_PTR = {1'b1, {IDX_W{1'b0}}};

  logic             occ_q   [N];
  logic             dirty_q [N];
  logic [VPN_W-1:0] vpn_q   [N];
  logic [PID_W-1:0] pid_q   [N];
  logic [PTR_W-1:0] next_q  [N];

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ_q[i]   <= 1'b0;
        dirty_q[i] <= 1'b0;
        vpn_q[i]   <= '0;
        pid_q[i]   <= '0;
        next_q[i]  <= NULL_PTR;
      end else if (new_en && (new_idx == IDX_W'(i))) begin
        occ_q[i]   <= 1'b1;
        dirty_q[i] <= new_dirty;
        vpn_q[i]   <= new_vpn;
        pid_q[i]   <= new_pid;
        next_q[i]  <= NULL_PTR;
      end else if (link_en && (link_idx == IDX_W'(i))) begin
        next_q[i]  <= link_ptr;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) free_mask[i] = ~occ_q[i];
  end

  assign rd_valid = occ_q[rd_idx];
  assign rd_vpn   = vpn_q[rd_idx];
  assign rd_pid   = pid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_next  = next_q[rd_idx];

  // R7
  new_slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_en |-> !occ_q[new_idx]);

  // R7
  link_at_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_en |-> (occ_q[link_idx] && next_q[link_idx][PTR_W-1]));

endmodule

// File: rtl/invpt_free_pick.sv
module invpt_free_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     mask,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/invpt_walk_ctrl.sv
module invpt_walk_ctrl
  import invpt_pkg::*;
#(
  parameter int N     = 8,
  parameter int VPN_W = 6,
  parameter int PID_W = 2,
  parameter int IDX_W = $clog2(N),
  parameter int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_frame,
  output logic             rsp_dirty,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [PID_W-1:0] ins_pid,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic             ins_dirty,
  output logic             ins_done,
  output logic             ins_ok,
  output logic [IDX_W-1:0] ins_frame,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_valid,
  input  logic [VPN_W-1:0] rd_vpn,
  input  logic [PID_W-1:0] rd_pid,
  input  logic             rd_dirty,
  input  logic [PTR_W-1:0] rd_next,
  input  logic             free_found,
  input  logic [IDX_W-1:0] free_idx,
  output logic             new_en,
  output logic [IDX_W-1:0] new_idx,
  output logic [VPN_W-1:0] new_vpn,
  output logic [PID_W-1:0] new_pid,
  output logic             new_dirty,
  output logic             link_en,
  output logic [IDX_W-1:0] link_idx,
  output logic [PTR_W-1:0] link_ptr
);

  walk_state_e      state_q;
  walk_op_e         op_q;
  logic [VPN_W-1:0] key_vpn_q;
  logic [PID_W-1:0] key_pid_q;
  logic             key_dirty_q;
  logic [IDX_W-1:0] cur_q;
  logic [IDX_W-1:0] steps_q;
  logic             res_hit_q;
  logic             res_ok_q;
  logic             res_dirty_q;
  logic [IDX_W-1:0] res_frame_q;

  logic             idle, walking;
  logic             take_ins, take_lk;
  logic             is_match, chain_end, at_limit;
  logic             finish, fin_hit, fin_ok, fin_dirty;
  logic [IDX_W-1:0] fin_frame;
  logic [IDX_W-1:0] ins_home, lk_home;

  assign idle      = (state_q == ST_IDLE);
  assign walking   = (state_q == ST_WALK);
  assign ins_ready = idle;
  assign lk_ready  = idle && !ins_valid;
  assign take_ins  = ins_valid && idle;
  assign take_lk   = lk_valid && lk_ready;
  assign ins_home  = ins_vpn[IDX_W-1:0];
  assign lk_home   = lk_vpn[IDX_W-1:0];

  assign rd_idx    = cur_q;
  assign is_match  = rd_valid && (rd_vpn == key_vpn_q) && (rd_pid == key_pid_q);
  assign chain_end = rd_next[PTR_W-1];
  assign at_limit  = (steps_q == IDX_W'(N - 1));

  assign new_vpn   = key_vpn_q;
  assign new_pid   = key_pid_q;
  assign new_dirty = key_dirty_q;
  assign link_idx  = cur_q;
  assign link_ptr  = {1'b0, free_idx};

  always_comb begin
    finish    = 1'b0;
    fin_hit   = 1'b0;
    fin_ok    = 1'b0;
    fin_dirty = 1'b0;
    fin_frame = '0;
    new_en    = 1'b0;
    new_idx   = cur_q;
    link_en   = 1'b0;
    if (walking) begin
      if (op_q == OP_LOOKUP) begin
        if (is_match) begin
          finish    = 1'b1;
          fin_hit   = 1'b1;
          fin_frame = cur_q;
          fin_dirty = rd_dirty;
        end else if (!rd_valid || chain_end || at_limit) begin
          finish    = 1'b1;
        end
      end else begin
        if (!rd_valid) begin
          finish    = 1'b1;
          new_en    = 1'b1;
          fin_ok    = 1'b1;
          fin_frame = cur_q;
        end else if (chain_end) begin
          finish = 1'b1;
          if (free_found) begin
            new_en    = 1'b1;
            new_idx   = free_idx;
            link_en   = 1'b1;
            fin_ok    = 1'b1;
            fin_frame = free_idx;
          end
        end else if (at_limit) begin
          finish = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_LOOKUP;
      key_vpn_q   <= '0;
      key_pid_q   <= '0;
      key_dirty_q <= 1'b0;
      cur_q       <= '0;
      steps_q     <= '0;
      res_hit_q   <= 1'b0;
      res_ok_q    <= 1'b0;
      res_dirty_q <= 1'b0;
      res_frame_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (take_ins) begin
            op_q        <= OP_INSERT;
            key_vpn_q   <= ins_vpn;
            key_pid_q   <= ins_pid;
            key_dirty_q <= ins_dirty;
            cur_q       <= ins_home;
            steps_q     <= '0;
            state_q     <= ST_WALK;
          end else if (take_lk) begin
            op_q        <= OP_LOOKUP;
            key_vpn_q   <= lk_vpn;
            key_pid_q   <= lk_pid;
            key_dirty_q <= 1'b0;
            cur_q       <= lk_home;
            steps_q     <= '0;
            state_q     <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (finish) begin
            res_hit_q   <= fin_hit;
            res_ok_q    <= fin_ok;
            res_dirty_q <= fin_dirty;
            res_frame_q <= fin_frame;
            state_q     <= ST_RESP;
          end else begin
            cur_q   <= rd_next[IDX_W-1:0];
            steps_q <= steps_q + 1'b1;
          end
        end
        ST_RESP: begin
          if ((op_q == OP_INSERT) || rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = (state_q == ST_RESP) && (op_q == OP_LOOKUP);
  assign ins_done  = (state_q == ST_RESP) && (op_q == OP_INSERT);
  assign rsp_hit   = res_hit_q;
  assign rsp_frame = res_frame_q;
  assign rsp_dirty = res_dirty_q;
  assign ins_ok    = res_ok_q;
  assign ins_frame = res_frame_q;

  logic [IDX_W:0] walk_cycles_q;
  always_ff @(posedge clk) begin
    if (!rst_n) walk_cycles_q <= '0;
    else if (walking) walk_cycles_q <= walk_cycles_q + 1'b1;
    else walk_cycles_q <= '0;
  end

  // R5
  walk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_cycles_q <= (IDX_W + 1)'(N));

  // R5
  no_same_cycle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> (!rsp_valid && !ins_done));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) &&
                                   $stable(rsp_frame) && $stable(rsp_dirty) && !lk_ready));

  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> ((rsp_frame == '0) && !rsp_dirty));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_done |=> !ins_done);

endmodule

// File: rtl/invpt_lookup.sv
module invpt_lookup #(
  parameter int NUM_FRAMES = 8,
  parameter int VPN_W      = 6,
  parameter int PID_W      = 2,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [IDX_W-1:0] rsp_frame,
  output logic             rsp_dirty,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [PID_W-1:0] ins_pid,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic             ins_dirty,
  output logic             ins_done,
  output logic             ins_ok,
  output logic [IDX_W-1:0] ins_frame
);

  localparam int PTR_W = IDX_W + 1;

  logic [IDX_W-1:0]      rd_idx;
  logic                  rd_valid;
  logic [VPN_W-1:0]      rd_vpn;
  logic [PID_W-1:0]      rd_pid;
  logic                  rd_dirty;
  logic [PTR_W-1:0]      rd_next;
  logic                  new_en;
  logic [IDX_W-1:0]      new_idx;
  logic [VPN_W-1:0]      new_vpn;
  logic [PID_W-1:0]      new_pid;
  logic                  new_dirty;
  logic                  link_en;
  logic [IDX_W-1:0]      link_idx;
  logic [PTR_W-1:0]      link_ptr;
  logic [NUM_FRAMES-1:0] free_mask;
  logic                  free_found;
  logic [IDX_W-1:0]      free_idx;

  invpt_entry_store #(
    .N(NUM_FRAMES), .VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W), .PTR_W(PTR_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_vpn(rd_vpn), .rd_pid(rd_pid),
    .rd_dirty(rd_dirty), .rd_next(rd_next),
    .new_en(new_en), .new_idx(new_idx), .new_vpn(new_vpn), .new_pid(new_pid),
    .new_dirty(new_dirty),
    .link_en(link_en), .link_idx(link_idx), .link_ptr(link_ptr),
    .free_mask(free_mask)
  );

  invpt_free_pick #(
    .N(NUM_FRAMES), .IDX_W(IDX_W)
  ) u_free (
    .mask(free_mask), .found(free_found), .idx(free_idx)
  );

  invpt_walk_ctrl #(
    .N(NUM_FRAMES), .VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W), .PTR_W(PTR_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pid(lk_pid), .lk_vpn(lk_vpn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_frame(rsp_frame), .rsp_dirty(rsp_dirty),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_pid(ins_pid),
    .ins_vpn(ins_vpn), .ins_dirty(ins_dirty),
    .ins_done(ins_done), .ins_ok(ins_ok), .ins_frame(ins_frame),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_vpn(rd_vpn), .rd_pid(rd_pid),
    .rd_dirty(rd_dirty), .rd_next(rd_next),
    .free_found(free_found), .free_idx(free_idx),
    .new_en(new_en), .new_idx(new_idx), .new_vpn(new_vpn), .new_pid(new_pid),
    .new_dirty(new_dirty),
    .link_en(link_en), .link_idx(link_idx), .link_ptr(link_ptr)
  );

endmodule

// File: tb/invpt_lookup_bench.sv
module invpt_lookup_bench;

  localparam int NF = 8;
  localparam int VW = 6;
  localparam int PW = 2;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic          lk_ready;
  logic [PW-1:0] lk_pid = '0;
  logic [VW-1:0] lk_vpn = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic          rsp_hit;
  logic [IW-1:0] rsp_frame;
  logic          rsp_dirty;
  logic          ins_valid = 1'b0;
  logic          ins_ready;
  logic [PW-1:0] ins_pid = '0;
  logic [VW-1:0] ins_vpn = '0;
  logic          ins_dirty = 1'b0;
  logic          ins_done;
  logic          ins_ok;
  logic [IW-1:0] ins_frame;

  int checks = 0;
  int fails  = 0;

  int m_occ   [NF];
  int m_vpn   [NF];
  int m_pid   [NF];
  int m_dirty [NF];
  int m_next  [NF];

  always #10 clk = ~clk;

  invpt_lookup u_invpt_lookup (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pid(lk_pid), .lk_vpn(lk_vpn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_frame(rsp_frame), .rsp_dirty(rsp_dirty),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_pid(ins_pid),
    .ins_vpn(ins_vpn), .ins_dirty(ins_dirty),
    .ins_done(ins_done), .ins_ok(ins_ok), .ins_frame(ins_frame)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic model_insert(input int vpn, input int pid, input int dirty,
                              output int ok, output int frame);
    int h, t, f;
    h = vpn % NF;
    ok = 0;
    frame = 0;
    if (m_occ[h] == 0) begin
      f = h;
      ok = 1;
    end else begin
      t = h;
      while (m_next[t] != -1) t = m_next[t];
      f = -1;
      for (int i = NF - 1; i >= 0; i--) if (m_occ[i] == 0) f = i;
      if (f >= 0) begin
        ok = 1;
        m_next[t] = f;
      end
    end
    if (ok == 1) begin
      m_occ[f] = 1; m_vpn[f] = vpn; m_pid[f] = pid; m_dirty[f] = dirty;
      m_next[f] = -1; frame = f;
    end
  endtask

  task automatic model_lookup(input int vpn, input int pid, output int hit,
                              output int frame, output int dirty, output int lat);
    int c, p;
    c = vpn % NF;
    p = 0;
    hit = 0; frame = 0; dirty = 0; lat = 0;
    forever begin
      if (m_occ[c] == 1 && m_vpn[c] == vpn && m_pid[c] == pid) begin
        hit = 1; frame = c; dirty = m_dirty[c]; lat = p + 1;
        break;
      end else if (m_occ[c] == 0 || m_next[c] == -1 || p == NF - 1) begin
        lat = p + 1;
        break;
      end
      c = m_next[c];
      p++;
    end
  endtask

  task automatic do_insert(input int vpn, input int pid, input int dirty, input string tag);
    int eok, efr, guard;
    model_insert(vpn, pid, dirty, eok, efr);
    @(negedge clk);
    ins_valid = 1'b1; ins_vpn = VW'(vpn); ins_pid = PW'(pid); ins_dirty = dirty[0];
    @(posedge clk);
    guard = 0;
    do begin
      @(negedge clk);
      ins_valid = 1'b0;
      guard++;
    end while (!ins_done && guard < 20);
    check(ins_done && (ins_ok == eok[0]) && (eok == 0 || ins_frame == IW'(efr)),
          $sformatf("%s insert vpn=%0d pid=%0d ok/frame", tag, vpn, pid),
          int'(ins_ok) * 100 + int'(ins_frame), eok * 100 + efr);
  endtask

  task automatic do_lookup(input int vpn, input int pid, input string tag);
    int eh, ef, ed, el, cnt;
    model_lookup(vpn, pid, eh, ef, ed, el);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = VW'(vpn); lk_pid = PW'(pid);
    @(posedge clk);
    cnt = 0;
    forever begin
      @(negedge clk);
      lk_valid = 1'b0;
      if (rsp_valid || cnt > 20) break;
      cnt++;
    end
    // R2 R3 R4 R5 R9: hit, frame, modify flag and latency against the model
    check(rsp_valid && (rsp_hit == eh[0]) && (rsp_frame == IW'(ef)) &&
          (rsp_dirty == ed[0]) && (cnt == el),
          $sformatf("%s lookup vpn=%0d pid=%0d hit/frame/dirty/latency", tag, vpn, pid),
          int'(rsp_hit) * 1000 + int'(rsp_frame) * 100 + int'(rsp_dirty) * 10 + cnt,
          eh * 1000 + ef * 100 + ed * 10 + el);
  endtask

  task automatic sweep(input string tag);
    for (int p = 0; p < (1 << PW); p++)
      for (int v = 0; v < (1 << VW); v++)
        do_lookup(v, p, tag);
  endtask

  int vec_vpn   [9] = '{3, 11, 19, 8, 3, 13, 6, 5, 40};
  int vec_pid   [9] = '{1, 1, 2, 0, 2, 3, 1, 0, 1};
  int vec_dirty [9] = '{1, 0, 1, 1, 0, 0, 1, 0, 1};

  initial begin
    for (int i = 0; i < NF; i++) begin
      m_occ[i] = 0; m_vpn[i] = 0; m_pid[i] = 0; m_dirty[i] = 0; m_next[i] = -1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check(!rsp_valid && !ins_done && ins_ready && lk_ready, "R1 reset outputs",
          int'(rsp_valid) * 1000 + int'(ins_done) * 100 + int'(ins_ready) * 10 + int'(lk_ready), 11);

    // R1 empty table: every pair misses after one entry
    sweep("R1 R4 empty");

    // R6 R7 R8 fill the table with colliding and merging chains
    for (int k = 0; k < 9; k++)
      do_insert(vec_vpn[k], vec_pid[k], vec_dirty[k], "R6 R7 R8");

    // R10 back-pressure on a two-step hit
    begin
      int eh, ef, ed, el;
      logic          h0, d0;
      logic [IW-1:0] f0;
      model_lookup(8, 0, eh, ef, ed, el);
      rsp_ready = 1'b0;
      @(negedge clk);
      lk_valid = 1'b1; lk_vpn = VW'(8); lk_pid = PW'(0);
      @(posedge clk);
      @(negedge clk);
      lk_valid = 1'b0;
      for (int g = 0; g < 20 && !rsp_valid; g++) @(negedge clk);
      h0 = rsp_hit; f0 = rsp_frame; d0 = rsp_dirty;
      check(rsp_valid && h0 == eh[0] && f0 == IW'(ef), "R10 held response content",
            int'(h0) * 100 + int'(f0), eh * 100 + ef);
      for (int w = 0; w < 3; w++) begin
        @(negedge clk);
        check(rsp_valid && !lk_ready && rsp_hit == h0 && rsp_frame == f0 && rsp_dirty == d0,
              "R10 response stable while stalled", int'(rsp_valid) * 10 + int'(lk_ready), 10);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      check(!rsp_valid && lk_ready, "R10 response released", int'(rsp_valid), 0);
    end

    // R11 both channels valid: insert first, lookup after
    begin
      int eok, efr, eh, ef, ed, el;
      model_insert(21, 3, 1, eok, efr);
      model_lookup(5, 0, eh, ef, ed, el);
      @(negedge clk);
      ins_valid = 1'b1; ins_vpn = VW'(21); ins_pid = PW'(3); ins_dirty = 1'b1;
      lk_valid = 1'b1; lk_vpn = VW'(5); lk_pid = PW'(0);
      #1;
      check(ins_ready && !lk_ready, "R11 insert has priority",
            int'(ins_ready) * 10 + int'(lk_ready), 10);
      @(posedge clk);
      @(negedge clk);
      ins_valid = 1'b0;
      for (int g = 0; g < 20 && !ins_done; g++) @(negedge clk);
      check(ins_done && ins_ok == eok[0], "R11 R8 insert on full table", int'(ins_ok), eok);
      @(negedge clk);
      check(!ins_done && lk_ready, "R11 done is one cycle", int'(ins_done), 0);
      @(posedge clk);
      @(negedge clk);
      lk_valid = 1'b0;
      for (int g = 0; g < 20 && !rsp_valid; g++) @(negedge clk);
      check(rsp_valid && rsp_hit == eh[0] && rsp_frame == IW'(ef) && rsp_dirty == ed[0],
            "R11 lookup served after insert", int'(rsp_hit) * 100 + int'(rsp_frame),
            eh * 100 + ef);
    end

    // R2 R3 R5 R8 R9 full sweep over the filled table
    sweep("R3 R9 full");
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

endmodule